// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs one short, software-assembled transaction on a serial flash device. Software fills an opcode register, three address registers and up to four data registers through a byte-wide register port. It then writes a control byte that picks the data length, whether an address is sent, the data direction and one of four chip selects, with the start bit set. The engine shifts the frame out on a single data line in SPI mode 0, with the serial clock taken straight from the system clock. On a read it captures the returned bytes into the data registers. The start bit reads back as set until the frame has finished.

A second register holds one hold bit per chip select. Clearing a hold bit keeps that select asserted between frames. Software uses this to join several short frames into one longer flash command, for example to send a four-byte address or to read more than four bytes.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register offsets on `reg_addr_i` are 0x0 opcode, 0x1/0x2/0x3 address low/mid/high, 0x4+i data byte i (i = 0..3), 0x8 control and 0x9 chip-select hold. Other offsets read as 0x00. After reset every register reads 0x00 except the hold register, which reads 0x0F. After reset all `spi_cs_no` are high and `spi_sclk_o` is low.
- R2: The control byte has data count in [2:0], address enable in [3], write direction in [4], select index in [6:5] and start/busy in [7]. Writing it with bit 7 set while idle starts a frame. Bit 7 reads 1 from the next cycle on and returns to 0 exactly 2*8*(1 + 3*aen + count) cycles after the start write was sampled.
- R3: Bytes go out in this order: the opcode, then the address bytes high, mid, low when the address is enabled, then the data bytes. During the data bytes of a read, MOSI is held at 0.
- R4: The bus runs in SPI mode 0, MSB first. SCLK idles low, and each SCLK level lasts one system clock. MOSI does not change across a rising SCLK edge. MISO is sampled at the end of each high phase.
- R5: On a write, data register i is sent as the i-th data byte, with byte 0 first.
- R6: On a read, the i-th received data byte is stored in data register i by the time bit 7 clears. Data registers at or above the count keep their values.
- R7: During a frame, `spi_cs_no[sel]` is low and the other selects follow their hold bits. When the frame ends, the select returns to its hold bit value.
- R8: A hold bit written 0 drives its select low while the engine is idle. Writing it back to 1 releases the select.
- R9: While busy, register writes of any kind (opcode, hold, control) have no effect.
- R10: A count of 0 sends only the opcode and any address bytes. A count written above 4 is stored and used as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the SCLK source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on offset) |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| spi_cs_no | output | 4 | Active-low chip selects |

## Verification
The bench builds the engine with its default sizes: three address bytes, four data registers and four selects. This makes every count from 0 to 4 reachable, along with both address settings and every select index. A behavioural flash model in the bench returns a byte pattern indexed by position since its select fell, so bytes read across joined frames can be predicted. The runs cover writes, reads, an empty data phase, count clamping, writes attempted while busy, and two frames joined under a held select.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned ADDR_BYTES = 3;
  localparam int unsigned DATA_MAX   = 4;
  localparam int unsigned NUM_CS     = 4;
  localparam int unsigned REG_AW     = 4;
  localparam int unsigned FRAME_BITS = 8 * (1 + ADDR_BYTES + DATA_MAX);
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [REG_AW-1:0] OFS_OPC  = 4'h0;
  localparam logic [REG_AW-1:0] OFS_ADR0 = 4'h1;
  localparam logic [REG_AW-1:0] OFS_DAT0 = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h8;
  localparam logic [REG_AW-1:0] OFS_HOLD = 4'h9;

  typedef struct packed {
    logic [1:0] sel;
    logic       wr;
    logic       aen;
    logic [2:0] cnt;
  } ctrl_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [REG_AW-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  input  logic                    busy_i,
  input  logic                    cap_i,
  input  logic [8*DATA_MAX-1:0]   cap_data_i,
  output logic [7:0]              rdata_o,
  output logic [7:0]              opc_o,
  output logic [8*ADDR_BYTES-1:0] adr_o,
  output logic [8*DATA_MAX-1:0]   dat_o,
  output ctrl_t                   ctrl_o,
  output ctrl_t                   ctrl_new_o,
  output logic [NUM_CS-1:0]       hold_o,
  output logic                    start_o
);
  logic wr_ok;

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (addr_i == OFS_CTRL) && wdata_i[7];

  always_comb begin
    ctrl_new_o.sel = wdata_i[6:5];
    ctrl_new_o.wr  = wdata_i[4];
    ctrl_new_o.aen = wdata_i[3];
    ctrl_new_o.cnt = (wdata_i[2:0] > 3'(DATA_MAX)) ? 3'(DATA_MAX) : wdata_i[2:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_o  <= '0;
      adr_o  <= '0;
      dat_o  <= '0;
      ctrl_o <= '0;
      hold_o <= '1;
    end else if (wr_ok) begin
      if (addr_i == OFS_OPC)  opc_o  <= wdata_i;
      if (addr_i == OFS_CTRL) ctrl_o <= ctrl_new_o;
      if (addr_i == OFS_HOLD) hold_o <= wdata_i[NUM_CS-1:0];
      for (int i = 0; i < ADDR_BYTES; i++)
        if (addr_i == REG_AW'(int'(OFS_ADR0) + i)) adr_o[8*i +: 8] <= wdata_i;
      for (int i = 0; i < DATA_MAX; i++)
        if (addr_i == REG_AW'(int'(OFS_DAT0) + i)) dat_o[8*i +: 8] <= wdata_i;
    end else if (cap_i) begin
      for (int i = 0; i < DATA_MAX; i++)
        if (i < int'(ctrl_o.cnt)) dat_o[8*i +: 8] <= cap_data_i[8*i +: 8];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_OPC)  rdata_o = opc_o;
    if (addr_i == OFS_CTRL) rdata_o = {busy_i, ctrl_o.sel, ctrl_o.wr, ctrl_o.aen, ctrl_o.cnt};
    if (addr_i == OFS_HOLD) rdata_o = 8'(hold_o);
    for (int i = 0; i < ADDR_BYTES; i++)
      if (addr_i == REG_AW'(int'(OFS_ADR0) + i)) rdata_o = adr_o[8*i +: 8];
    for (int i = 0; i < DATA_MAX; i++)
      if (addr_i == REG_AW'(int'(OFS_DAT0) + i)) rdata_o = dat_o[8*i +: 8];
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  ctrl_t ctrl_new_i,
  input  ctrl_t ctrl_i,
  output logic  busy_o,
  output logic  sclk_o,
  output logic  shift_o,
  output logic  data_ph_o,
  output logic  last_o
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] total;
  logic             ph_q;

  always_comb begin
    total = CNT_W'(8 * (1 + (ctrl_new_i.aen ? ADDR_BYTES : 0) + int'(ctrl_new_i.cnt)));
  end

  assign sclk_o    = busy_o && ph_q;
  assign shift_o   = busy_o && ph_q;
  assign last_o    = (left_q == CNT_W'(1));
  assign data_ph_o = left_q <= CNT_W'(8 * int'(ctrl_i.cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      ph_q   <= 1'b0;
      left_q <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        ph_q   <= 1'b0;
        left_q <= total;
      end
    end else begin
      ph_q <= !ph_q;
      if (ph_q) begin
        left_q <= left_q - CNT_W'(1);
        if (last_o) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
  import spi_cmd_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  ctrl_t                   ctrl_new_i,
  input  ctrl_t                   ctrl_i,
  input  logic [7:0]              opc_i,
  input  logic [8*ADDR_BYTES-1:0] adr_i,
  input  logic [8*DATA_MAX-1:0]   dat_i,
  input  logic                    busy_i,
  input  logic                    shift_i,
  input  logic                    data_ph_i,
  input  logic                    last_i,
  input  logic                    miso_i,
  output logic                    mosi_o,
  output logic                    cap_o,
  output logic [8*DATA_MAX-1:0]   cap_data_o
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [FRAME_BITS-1:0] frame;
  logic [8*DATA_MAX-1:0] rx_q;
  logic [8*DATA_MAX-1:0] rx_nxt;
  logic                  rd_data;

  // frame is left-aligned: opcode, optional address (high first), data byte 0 first
  always_comb begin
    frame = '0;
    frame[FRAME_BITS-1 -: 8] = opc_i;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (ctrl_new_i.aen)
        frame[FRAME_BITS-1-8*(1+ADDR_BYTES+i) -: 8] = dat_i[8*i +: 8];
      else
        frame[FRAME_BITS-1-8*(1+i) -: 8] = dat_i[8*i +: 8];
    end
    if (ctrl_new_i.aen)
      for (int i = 0; i < ADDR_BYTES; i++)
        frame[FRAME_BITS-1-8*(1+i) -: 8] = adr_i[8*(ADDR_BYTES-1-i) +: 8];
  end

  assign rd_data = data_ph_i && !ctrl_i.wr;
  assign mosi_o  = busy_i && !rd_data && tx_q[FRAME_BITS-1];
  assign rx_nxt  = {rx_q[8*DATA_MAX-2:0], miso_i};
  assign cap_o   = shift_i && last_i && rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (start_i) begin
      tx_q <= frame;
    end else if (shift_i) begin
      tx_q <= tx_q << 1;
      if (rd_data) rx_q <= rx_nxt;
    end
  end

  // first received byte sits highest in rx_nxt; map it to data register 0
  always_comb begin
    cap_data_o = '0;
    for (int i = 0; i < DATA_MAX; i++) begin
      int pos;
      pos = int'(ctrl_i.cnt) - 1 - i;
      if (pos >= 0) cap_data_o[8*i +: 8] = rx_nxt[8*pos +: 8];
    end
  end
endmodule

// File: rtl/spi_cmd_csel.sv
module spi_cmd_csel
  import spi_cmd_pkg::*;
(
  input  logic              busy_i,
  input  logic [1:0]        sel_i,
  input  logic [NUM_CS-1:0] hold_i,
  output logic [NUM_CS-1:0] cs_no
);
  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign cs_no[k] = hold_i[k] && !(busy_i && (sel_i == 2'(k)));
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              spi_sclk_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic [NUM_CS-1:0] spi_cs_no
);
  logic [7:0]              opc;
  logic [8*ADDR_BYTES-1:0] adr;
  logic [8*DATA_MAX-1:0]   dat;
  logic [8*DATA_MAX-1:0]   cap_data;
  logic [NUM_CS-1:0]       hold;
  ctrl_t                   ctrl, ctrl_new;
  logic start, busy, shift, data_ph, last, cap;

  spi_cmd_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .cap_i(cap), .cap_data_i(cap_data), .rdata_o(reg_rdata_o),
    .opc_o(opc), .adr_o(adr), .dat_o(dat), .ctrl_o(ctrl), .ctrl_new_o(ctrl_new),
    .hold_o(hold), .start_o(start)
  );

  spi_cmd_seq u_seq (
    .clk_i, .rst_ni, .start_i(start), .ctrl_new_i(ctrl_new), .ctrl_i(ctrl),
    .busy_o(busy), .sclk_o(spi_sclk_o), .shift_o(shift), .data_ph_o(data_ph), .last_o(last)
  );

  spi_cmd_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .ctrl_new_i(ctrl_new), .ctrl_i(ctrl),
    .opc_i(opc), .adr_i(adr), .dat_i(dat), .busy_i(busy), .shift_i(shift),
    .data_ph_i(data_ph), .last_i(last), .miso_i(spi_miso_i), .mosi_o(spi_mosi_o),
    .cap_o(cap), .cap_data_o(cap_data)
  );

  spi_cmd_csel u_csel (
    .busy_i(busy), .sel_i(ctrl.sel), .hold_i(hold), .cs_no(spi_cs_no)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
  import spi_cmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              start,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic [NUM_CS-1:0] hold,
  input logic              we,
  input logic [REG_AW-1:0] addr,
  input logic [7:0]        opc
);
  p_idle_sclk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sclk);
  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk) |-> $stable(mosi));
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start) |=> busy);
  p_cs_in_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk |-> ($countones(~cs_n) >= 1));
  p_cs_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && (&hold)) |-> (&cs_n));
  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we && addr == OFS_OPC) |=> $stable(opc));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .start(start), .sclk(spi_sclk_o),
  .mosi(spi_mosi_o), .cs_n(spi_cs_no), .hold(hold), .we(reg_we_i),
  .addr(reg_addr_i), .opc(opc)
);

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk, mosi, miso;
  logic [3:0] cs_n;

  int checks = 0;
  int errs = 0;
  int chain_idx = 0;
  int rbits = 0;
  int tbits = 0;
  logic [7:0] sr = '0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .spi_cs_no(cs_n)
  );

  function automatic logic [7:0] resp(int j);
    return 8'hC3 ^ 8'(j * 37);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // flash model: MISO walks a byte pattern, bit position advanced on falling SCLK
  assign miso = resp(tbits / 8)[7 - (tbits % 8)];

  always @(posedge (&cs_n)) begin
    tbits = 0;
    rbits = 0;
  end

  always @(negedge sclk) begin
    #1;
    if (!(&cs_n)) tbits++;
  end

  // scoreboard monitor
  always @(posedge sclk) begin
    sr = {sr[6:0], mosi};
    rbits++;
    if (rbits == 8) begin
      rbits = 0;
      if (exp_q.size() == 0) chk("R3 unexpected byte", {24'h0, sr}, 32'hFFFF_FFFF);
      else chk("R3 mosi byte order", {24'h0, sr}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] adr, input int cnt,
                     input bit aen, input bit wr, input logic [1:0] sel,
                     input logic [31:0] dat, input bit poke, input logic [3:0] hold);
    int eff, hdr, base, nb;
    logic [7:0] v;
    eff  = (cnt > 4) ? 4 : cnt;
    hdr  = 1 + (aen ? 3 : 0);
    base = chain_idx;
    nb   = 8 * (hdr + eff);
    reg_wr(4'h0, op);
    for (int i = 0; i < 3; i++) reg_wr(4'(1 + i), adr[8*i +: 8]);
    if (wr) for (int i = 0; i < eff; i++) reg_wr(4'(4 + i), dat[8*i +: 8]);
    exp_q.push_back(op);
    if (aen) for (int i = 2; i >= 0; i--) exp_q.push_back(adr[8*i +: 8]);
    for (int i = 0; i < eff; i++) exp_q.push_back(wr ? dat[8*i +: 8] : 8'h00);
    @(negedge clk);
    we = 1'b1; addr = 4'h8; wdata = {1'b1, sel, wr, aen, 3'(cnt)};
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    #1 chk("R7 select asserted in frame", {28'h0, cs_n}, {28'h0, hold & ~(4'b1 << sel)});
    for (int k = 1; k < 2 * nb; k++) begin
      @(negedge clk);
      if (poke && k == 3) begin we = 1'b1; addr = 4'h0; wdata = 8'hEE; end
      if (poke && k == 4) begin we = 1'b1; addr = 4'h9; wdata = 8'h00; end
      if (poke && k == 5) begin we = 1'b0; addr = 4'h8; end
      if (k == 2 * nb - 1) #1 chk("R2 busy bit still set", {31'h0, rdata[7]}, 32'h1);
    end
    @(negedge clk);
    #1 chk("R2 busy bit clears on time", {31'h0, rdata[7]}, 32'h0);
    chk("R7 select after frame", {28'h0, cs_n}, {28'h0, hold});
    if (!wr) for (int i = 0; i < eff; i++) begin
      reg_rd(4'(4 + i), v);
      chk("R6 captured data byte", {24'h0, v}, {24'h0, resp(base + hdr + i)});
    end
    chain_idx = !hold[sel] ? base + hdr + eff : 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_rd(4'h0, v); chk("R1 opcode reset", {24'h0, v}, 32'h00);
    reg_rd(4'h8, v); chk("R1 control reset", {24'h0, v}, 32'h00);
    reg_rd(4'h9, v); chk("R1 hold reset", {24'h0, v}, 32'h0F);
    reg_rd(4'hC, v); chk("R1 unmapped offset", {24'h0, v}, 32'h00);
    chk("R1 selects idle", {28'h0, cs_n}, 32'hF);
    chk("R1 sclk idle", {31'h0, sclk}, 32'h0);
    reg_wr(4'h2, 8'h77);
    reg_rd(4'h2, v); chk("R1 address mid readback", {24'h0, v}, 32'h77);

    // R3 R5 write with address, two bytes, select 0
    run(8'h02, 24'h123456, 2, 1, 1, 2'd0, 32'h0000_55AA, 0, 4'hF);
    // R6 read with address, four bytes, select 2
    run(8'h03, 24'hABCDEF, 4, 1, 0, 2'd2, 32'h0, 0, 4'hF);
    // R10 count 0: opcode only, select 3
    run(8'h06, 24'h0, 0, 0, 1, 2'd3, 32'h0, 0, 4'hF);
    // R6 read three bytes without address; register 3 keeps earlier value
    run(8'h9F, 24'h0, 3, 0, 0, 2'd1, 32'h0, 0, 4'hF);
    reg_rd(4'h7, v); chk("R6 unused data register kept", {24'h0, v}, {24'h0, resp(7)});

    // R8 joined frames under held select 1
    reg_wr(4'h9, 8'h0D);
    @(negedge clk);
    chk("R8 held select low while idle", {28'h0, cs_n}, 32'hD);
    run(8'h05, 24'h0, 1, 0, 0, 2'd1, 32'h0, 0, 4'hD);
    chk("R8 select held between frames", {28'h0, cs_n}, 32'hD);
    run(8'h00, 24'h0, 2, 0, 0, 2'd1, 32'h0, 0, 4'hD);
    reg_wr(4'h9, 8'h0F);
    @(negedge clk);
    chk("R8 release held select", {28'h0, cs_n}, 32'hF);

    // R9 writes during busy ignored
    run(8'h01, 24'h0, 1, 0, 1, 2'd0, 32'h0000_003C, 1, 4'hF);
    reg_rd(4'h0, v); chk("R9 opcode unchanged", {24'h0, v}, 32'h01);
    reg_rd(4'h9, v); chk("R9 hold unchanged", {24'h0, v}, 32'h0F);
    chk("R9 selects released", {28'h0, cs_n}, 32'hF);

    // R10 count above 4 clamps
    run(8'h0B, 24'h0, 7, 0, 0, 2'd2, 32'h0, 0, 4'hF);
    reg_rd(4'h8, v); chk("R10 clamped count readback", {24'h0, v}, {24'h0, 1'b0, 2'd2, 1'b0, 1'b0, 3'd4});

    repeat (4) @(negedge clk);
    chk("R3 all expected bytes seen", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule